// File: doc/BRIEF.md
# Serial Link Transmit Frame Formatter

This block sits on the transmit side of a point-to-point serial link. It takes one parallel word per frame slot and turns it into a coded serial frame. Each frame is the payload plus a 4-bit header, sent MSB first on `sout`, one bit per cycle in which the bit-rate enable `bit_en` is high. The two active-low strobes pick what a frame carries. With `cav_n` low it carries a control word, and this wins over `dav_n`. With only `dav_n` low it carries user data. With neither low it carries a fill frame, which keeps the line busy. While the link is starting up, a training select swaps the ordinary fill for one of two training patterns. The line is kept DC balanced: whole payloads are inverted against a signed running disparity, and the inversion is marked in the header.

The word side works as a stream. `frm_ready` plays the part of ready and a low strobe plays the part of valid. A word is taken on a clock edge where `frm_ready` and `bit_en` are both high. Until then the source must hold `din`, `flag` and the strobes steady. Strobes and data presented in any other cycle are ignored. In double-frame mode one 2·DATA_W word is taken per handshake. It goes out as two frames, lower half first, and `frm_ready` stays low for the second half. The payload width DATA_W is fixed at elaboration (16 or 20 in practice), so a frame is DATA_W+4 bits.

Top module: `txfmt_top`

## Requirements
- R1: A frame is DATA_W+4 bits and is sent MSB first. Header bit 3 goes first, then header bits 2..0 (the frame-kind code), then the payload from bit DATA_W-1 down to 0. A new frame starts after exactly DATA_W+4 enabled bit times.
- R2: On a handshake with `cav_n`=0, whatever the state of `dav_n`, the kind code is 001. The payload is `din[DATA_W-3:0]` with its top two bits forced to 0, before any inversion.
- R3: On a handshake with `cav_n`=1, `dav_n`=0 and `dbl_mode`=0, the payload is `din[DATA_W-1:0]`. The kind code is 010 when `flag`=0 and 011 when `flag`=1.
- R4: When neither strobe is low and `train_sel`=00, a fill frame goes out. Its kind code is 100, and its payload is ones in the upper half and zeros in the lower half.
- R5: With both strobes high, `train_sel`=01 sends training-0: kind code 101, payload alternating 1010… starting with 1 at the MSB. `train_sel`=10 or 11 sends training-1: kind code 110, payload repeating 1100… from the MSB.
- R6: Payload disparity d is the count of ones minus the count of zeros. The payload is inverted, and header bit 3 is set, exactly when d≠0, the running disparity is nonzero, and both have the same sign. The running disparity then moves by −d if the payload was inverted and by +d if it was not.
- R7: The disparity summed over all transmitted payload bits since reset never leaves the range −DATA_W..+DATA_W.
- R8: With `dbl_mode`=1, a data handshake sends `din[DATA_W-1:0]` with kind 010. The next frame then sends `din[2·DATA_W-1:DATA_W]` with kind 011, whatever the strobes say, and `frm_ready` is low during that second frame.
- R9: `frm_ready` is high only during the last bit of a frame, with reset released and no second half pending. Inputs have no effect in any cycle other than a handshake.
- R10: While `rst_n` is low (synchronous), `sout` and `frm_ready` are 0 and the running disparity is cleared. The first frame after release is training-0 with header bit 3 clear.
- R11: Every frame's 3-bit kind code contains both a 0 and a 1, so there is at least one transition in the header.
- R12: A cycle with `bit_en` low leaves `sout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable; one serial bit per enabled cycle |
| dbl_mode | input | 1 | Double-frame mode select |
| train_sel | input | 2 | Idle pattern: 00 fill, 01 training-0, 1x training-1 |
| dav_n | input | 1 | Active-low data available |
| cav_n | input | 1 | Active-low control available (priority) |
| flag | input | 1 | Extra data bit for single-mode data frames |
| din | input | 2·DATA_W | Word; lower DATA_W bits used except in double mode |
| frm_ready | output | 1 | Word accepted on an edge where this and bit_en are high |
| sout | output | 1 | Serial line bit |

## Verification
The bench builds the block with DATA_W=16, which gives 20-bit frames, 14-bit control words and 32-bit double words. Since the payload is only 16 bits wide, the all-ones and all-zeros words used in the bench reach a disparity of ±16 in one frame. This pushes the running total to its bound and forces inversions on successive frames. Bit-enable patterns that are gapped and irregular, strobes toggled at random and a reset in mid-frame bring priority conflicts, ignored non-handshake cycles and double-frame halves mixed with fill frames within reach of the per-clock comparison.

// File: rtl/txfmt_pkg.sv
package txfmt_pkg;

  typedef enum logic [2:0] {
    KIND_CTRL   = 3'b001,
    KIND_DATA0  = 3'b010,
    KIND_DATA1  = 3'b011,
    KIND_FILL   = 3'b100,
    KIND_TRAIN0 = 3'b101,
    KIND_TRAIN1 = 3'b110
  } frame_kind_e;

  // Idle payload patterns, all with zero disparity for widths divisible by 4.
  function automatic logic [63:0] idle_pattern(input frame_kind_e k, input int w);
    logic [63:0] p;
    p = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < w) begin
        case (k)
          KIND_TRAIN0: p[i] = ((i % 2) == 1);
          KIND_TRAIN1: p[i] = (((i / 2) % 2) == 1);
          default:     p[i] = (i >= (w / 2));
        endcase
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/txfmt_select.sv
module txfmt_select
  import txfmt_pkg::*;
#(
  parameter int DATA_W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  dbl_mode,
  input  logic                  dav_n,
  input  logic                  cav_n,
  input  logic                  flag,
  input  logic [1:0]            train_sel,
  input  logic [2*DATA_W-1:0]   din,
  output frame_kind_e           kind,
  output logic [DATA_W-1:0]     payload,
  output logic                  pend
);
  localparam int CTRL_W = DATA_W - 2;
  localparam logic [63:0] FILL_W64 = idle_pattern(KIND_FILL, DATA_W);
  localparam logic [63:0] TR0_W64  = idle_pattern(KIND_TRAIN0, DATA_W);
  localparam logic [63:0] TR1_W64  = idle_pattern(KIND_TRAIN1, DATA_W);

  logic              pend_q;
  logic [DATA_W-1:0] upper_q;

  always_comb begin
    kind    = KIND_FILL;
    payload = FILL_W64[DATA_W-1:0];
    if (pend_q) begin
      kind    = KIND_DATA1;
      payload = upper_q;
    end else if (!cav_n) begin
      kind    = KIND_CTRL;
      payload = {{(DATA_W-CTRL_W){1'b0}}, din[CTRL_W-1:0]};
    end else if (!dav_n) begin
      kind    = (!dbl_mode && flag) ? KIND_DATA1 : KIND_DATA0;
      payload = din[DATA_W-1:0];
    end else begin
      case (train_sel)
        2'b00: begin
          kind    = KIND_FILL;
          payload = FILL_W64[DATA_W-1:0];
        end
        2'b01: begin
          kind    = KIND_TRAIN0;
          payload = TR0_W64[DATA_W-1:0];
        end
        default: begin
          kind    = KIND_TRAIN1;
          payload = TR1_W64[DATA_W-1:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      upper_q <= '0;
    end else if (load) begin
      if (pend_q) begin
        pend_q <= 1'b0;
      end else if (cav_n && !dav_n && dbl_mode) begin
        pend_q  <= 1'b1;
        upper_q <= din[2*DATA_W-1:DATA_W];
      end
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/txfmt_balance.sv
module txfmt_balance #(
  parameter int DATA_W = 20,
  parameter int RD_W   = $clog2(DATA_W + 1) + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [DATA_W-1:0]       raw,
  output logic                    inv,
  output logic [DATA_W-1:0]       line_bits,
  output logic signed [RD_W-1:0]  run_disp
);
  localparam int CNT_W = RD_W - 2;

  logic [CNT_W-1:0]       ones;
  logic signed [RD_W-1:0] disp;
  logic signed [RD_W-1:0] run_q;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) begin
      ones = ones + CNT_W'(raw[i]);
    end
  end

  assign disp = $signed({1'b0, ones, 1'b0}) - $signed(RD_W'(DATA_W));

  // Invert only when the frame would push the running total further out.
  assign inv = (disp != '0) && (run_q != '0) && (disp[RD_W-1] == run_q[RD_W-1]);
  assign line_bits = inv ? ~raw : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (load) begin
      run_q <= inv ? (run_q - disp) : (run_q + disp);
    end
  end

  assign run_disp = run_q;

endmodule

// File: rtl/txfmt_shift.sv
module txfmt_shift #(
  parameter int                 FRAME_W     = 24,
  parameter logic [FRAME_W-1:0] RESET_FRAME = '0,
  parameter int                 IDX_W       = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic [FRAME_W-1:0] next_frame,
  output logic               sout,
  output logic               last,
  output logic [IDX_W-1:0]   bit_idx,
  output logic [FRAME_W-1:0] cur_frame
);
  logic [FRAME_W-1:0] sh_q;
  logic [IDX_W-1:0]   idx_q;

  assign last = (idx_q == IDX_W'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= RESET_FRAME;
      idx_q <= '0;
    end else if (bit_en) begin
      if (last) begin
        sh_q  <= next_frame;
        idx_q <= '0;
      end else begin
        sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign sout      = rst_n & sh_q[FRAME_W-1];
  assign bit_idx   = idx_q;
  assign cur_frame = sh_q;

endmodule

// File: rtl/txfmt_top.sv
module txfmt_top
  import txfmt_pkg::*;
#(
  parameter int DATA_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic                dbl_mode,
  input  logic [1:0]          train_sel,
  input  logic                dav_n,
  input  logic                cav_n,
  input  logic                flag,
  input  logic [2*DATA_W-1:0] din,
  output logic                frm_ready,
  output logic                sout
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int RD_W    = $clog2(DATA_W + 1) + 2;
  localparam logic [63:0] TR0_W64 = idle_pattern(KIND_TRAIN0, DATA_W);
  localparam logic [FRAME_W-1:0] RESET_FRAME = {1'b0, KIND_TRAIN0, TR0_W64[DATA_W-1:0]};

  generate
    if ((DATA_W % 4) != 0 || DATA_W < 8 || DATA_W > 60) begin : g_bad_width
      $error("txfmt_top: DATA_W must be a multiple of 4 between 8 and 60");
    end
  endgenerate

  frame_kind_e            kind;
  logic [DATA_W-1:0]      payload;
  logic [DATA_W-1:0]      line_bits;
  logic                   inv;
  logic                   pend;
  logic                   last;
  logic                   load;
  logic [IDX_W-1:0]       bit_idx;
  logic [FRAME_W-1:0]     cur_frame;
  logic [FRAME_W-1:0]     next_frame;
  logic signed [RD_W-1:0] run_disp;

  assign load       = rst_n & bit_en & last;
  assign frm_ready  = rst_n & last & ~pend;
  assign next_frame = {inv, kind, line_bits};

  txfmt_select #(.DATA_W(DATA_W)) sel_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .dbl_mode  (dbl_mode),
    .dav_n     (dav_n),
    .cav_n     (cav_n),
    .flag      (flag),
    .train_sel (train_sel),
    .din       (din),
    .kind      (kind),
    .payload   (payload),
    .pend      (pend)
  );

  txfmt_balance #(.DATA_W(DATA_W), .RD_W(RD_W)) bal_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .raw       (payload),
    .inv       (inv),
    .line_bits (line_bits),
    .run_disp  (run_disp)
  );

  txfmt_shift #(.FRAME_W(FRAME_W), .RESET_FRAME(RESET_FRAME), .IDX_W(IDX_W)) shf_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .next_frame (next_frame),
    .sout       (sout),
    .last       (last),
    .bit_idx    (bit_idx),
    .cur_frame  (cur_frame)
  );

endmodule

// File: rtl/txfmt_chk.sv
module txfmt_chk
  import txfmt_pkg::*;
#(
  parameter int DATA_W = 20
) (
  input logic                                       clk,
  input logic                                       rst_n,
  input logic                                       bit_en,
  input logic                                       sout,
  input logic                                       frm_ready,
  input logic                                       last,
  input logic                                       pend,
  input logic [$clog2(DATA_W+4)-1:0]                bit_idx,
  input logic [DATA_W+3:0]                          cur_frame,
  input logic signed [$clog2(DATA_W+1)+1:0]         run_disp
);
  localparam int FRAME_W = DATA_W + 4;

  AST_SOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(sout)); // R12

  AST_READY_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |-> last); // R9

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && last) |=> (bit_idx == '0)); // R1

  AST_FIRST_HALF_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> (cur_frame[FRAME_W-2:FRAME_W-4] == KIND_DATA0)); // R8

  AST_DISP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(run_disp) <= DATA_W) && ($signed(run_disp) >= -DATA_W)); // R7

  AST_KIND_TRANSITION: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_idx == '0) |-> ((cur_frame[FRAME_W-2:FRAME_W-4] != 3'b000) &&
                          (cur_frame[FRAME_W-2:FRAME_W-4] != 3'b111))); // R11

endmodule

bind txfmt_top txfmt_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .sout      (sout),
  .frm_ready (frm_ready),
  .last      (last),
  .pend      (pend),
  .bit_idx   (bit_idx),
  .cur_frame (cur_frame),
  .run_disp  (run_disp)
);

// File: tb/txfmt_top_tb_top.sv
`timescale 1ns/1ps
module txfmt_top_tb_top;
  localparam int DW = 16;
  localparam int FW = DW + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_en = 1'b0;
  logic          dbl_mode = 1'b0;
  logic [1:0]    train_sel = 2'b01;
  logic          dav_n = 1'b1;
  logic          cav_n = 1'b1;
  logic          flag = 1'b0;
  logic [2*DW-1:0] din = '0;
  logic          frm_ready;
  logic          sout;

  always #4 clk = ~clk;

  txfmt_top #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .dbl_mode(dbl_mode),
    .train_sel(train_sel), .dav_n(dav_n), .cav_n(cav_n), .flag(flag),
    .din(din), .frm_ready(frm_ready), .sout(sout)
  );

  int checks = 0;
  int errors = 0;
  int en_mode = 0;
  int cyc = 0;
  bit started = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int            m_cnt = 0;
  int            m_run = 0;
  bit            m_pend = 0;
  logic [DW-1:0] m_upper = '0;
  logic [FW-1:0] m_frame = '0;
  string         m_tag = "R10";

  function automatic logic [DW-1:0] pat(input int sel);
    logic [DW-1:0] p;
    for (int i = 0; i < DW; i++) begin
      if (sel == 0)      p[i] = (i >= DW/2);
      else if (sel == 1) p[i] = ((i % 2) == 1);
      else               p[i] = (((i / 2) % 2) == 1);
    end
    return p;
  endfunction

  task automatic model_load();
    logic [2:0]    k;
    logic [DW-1:0] pl;
    int ones, d;
    bit inv;
    if (m_pend) begin
      k = 3'b011; pl = m_upper; m_pend = 0; m_tag = "R8";
    end else if (!cav_n) begin
      k = 3'b001; m_tag = "R2";
      for (int i = 0; i < DW; i++) pl[i] = (i < DW-2) ? din[i] : 1'b0;
    end else if (!dav_n) begin
      pl = din[DW-1:0];
      if (dbl_mode) begin
        k = 3'b010; m_pend = 1; m_upper = din[2*DW-1:DW]; m_tag = "R8";
      end else begin
        k = flag ? 3'b011 : 3'b010; m_tag = "R3";
      end
    end else if (train_sel == 2'b00) begin
      k = 3'b100; pl = pat(0); m_tag = "R4";
    end else if (train_sel == 2'b01) begin
      k = 3'b101; pl = pat(1); m_tag = "R5";
    end else begin
      k = 3'b110; pl = pat(2); m_tag = "R5";
    end
    ones = 0;
    for (int i = 0; i < DW; i++) ones += int'(pl[i]);
    d = 2*ones - DW;
    inv = (d != 0) && (m_run != 0) && ((d > 0) == (m_run > 0));
    if (inv) begin
      pl = ~pl; m_run -= d; m_tag = "R6";
    end else begin
      m_run += d;
    end
    m_frame = {inv, k, pl};
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_pend = 0;
      m_frame = {1'b0, 3'b101, pat(1)};
      m_tag = "R10";
      started = 1;
    end else if (bit_en) begin
      if (m_cnt == FW-1) begin
        model_load();
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end
  end

  // ---------------- comparison ----------------
  logic [FW-1:0] obs = '0;
  int  line_acc = 0;
  bit  prev_en = 1'b1;
  bit  prev_rst = 1'b0;
  logic prev_sout = 1'b0;

  always @(negedge clk) begin
    logic exp_bit, exp_rdy;
    int ones;
    cyc++;
    if (started) begin
      exp_bit = rst_n ? m_frame[FW-1-m_cnt] : 1'b0;
      chk(sout === exp_bit, m_tag, 64'(sout), 64'(exp_bit));
      exp_rdy = rst_n && (m_cnt == FW-1) && !m_pend;
      chk(frm_ready === exp_rdy, "R9", 64'(frm_ready), 64'(exp_rdy));
      if (rst_n && prev_rst && !prev_en)
        chk(sout === prev_sout, "R12", 64'(sout), 64'(prev_sout));
      if (!rst_n) line_acc = 0;
      if (rst_n && bit_en) begin
        obs = {obs[FW-2:0], sout};
        if (m_cnt == FW-1) begin
          chk(obs === m_frame, "R1", 64'(obs), 64'(m_frame));
          chk(obs[FW-2:FW-4] != 3'b000 && obs[FW-2:FW-4] != 3'b111, "R11",
              64'(obs[FW-2:FW-4]), 64'(m_frame[FW-2:FW-4]));
          ones = 0;
          for (int i = 0; i < DW; i++) ones += int'(obs[i]);
          line_acc += 2*ones - DW;
          chk(line_acc <= DW && line_acc >= -DW, "R7", 64'(line_acc), 64'(DW));
        end
      end
    end
    prev_en = bit_en;
    prev_rst = rst_n;
    prev_sout = sout;
  end

  // ---------------- bit enable pattern ----------------
  initial begin
    forever begin
      @(posedge clk); #1;
      case (en_mode)
        0: bit_en = 1'b1;
        1: bit_en = ((cyc % 4) != 2);
        default: bit_en = (($urandom % 3) != 0);
      endcase
    end
  end

  task automatic put(input bit c_n, input bit d_n, input bit f, input logic [2*DW-1:0] w);
    cav_n = c_n; dav_n = d_n; flag = f; din = w;
    forever begin
      @(negedge clk);
      if (frm_ready && bit_en) break;
    end
    @(posedge clk); #2;
    cav_n = 1'b1; dav_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (5) @(negedge clk);
    chk(sout === 1'b0, "R10", 64'(sout), 64'h0);
    chk(frm_ready === 1'b0, "R10", 64'(frm_ready), 64'h0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    idle(3*FW);
    train_sel = 2'b10; idle(2*FW);
    train_sel = 2'b11; idle(2*FW);
    train_sel = 2'b00; idle(2*FW);

    en_mode = 1;
    // R3: data frames, both flag values, disparity extremes for R6
    put(1, 0, 0, 32'h0000_FFFF);
    put(1, 0, 1, 32'h0000_FFFF);
    put(1, 0, 0, 32'h0000_FFFF);
    put(1, 0, 1, 32'h0000_0000);
    put(1, 0, 0, 32'h0000_0000);
    put(1, 0, 1, 32'h0000_A5A5);
    for (int i = 0; i < 20; i++) put(1, 0, 1'($urandom), 32'($urandom));
    // R2: control truncation and priority over data
    put(0, 1, 0, 32'hFFFF_FFFF);
    put(0, 0, 1, 32'h1234_C3C3);
    put(0, 0, 0, 32'h0000_0001);
    idle(FW);
    // R8: double-frame mode
    dbl_mode = 1'b1;
    put(1, 0, 0, 32'hFFFF_0000);
    put(1, 0, 1, 32'h0000_FFFF);
    for (int i = 0; i < 10; i++) put(1, 0, 1'($urandom), 32'($urandom));
    put(0, 1, 0, 32'h0F0F_3FFF);
    idle(3*FW);
    dbl_mode = 1'b0;

    // Random strobes every cycle, irregular enables
    en_mode = 2;
    for (int i = 0; i < 4000; i++) begin
      cav_n = (($urandom % 4) != 0);
      dav_n = 1'($urandom);
      flag = 1'($urandom);
      dbl_mode = (($urandom % 5) == 0);
      train_sel = 2'($urandom);
      din = 32'($urandom);
      @(posedge clk); #2;
    end
    cav_n = 1'b1; dav_n = 1'b1; dbl_mode = 1'b0; train_sel = 2'b00;

    // Mid-frame reset, then traffic again (R10)
    idle(7);
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    en_mode = 0;
    idle(FW + 3);
    for (int i = 0; i < 10; i++) put(1, 0, 1'($urandom), 32'($urandom));
    idle(2*FW);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual=run still active expected=completion before %0d cycles", 150000);
    summary();
    $finish;
  end

endmodule